// File: doc/BRIEF.md
# Instruction Prefetch Queue with Queue Status

This block sits between a bus interface and an instruction consumer. It fetches code ahead of execution, one 16-bit word per bus transaction, and keeps up to six opcode bytes. It also reports on a two-bit status output what the queue did in the previous clock. The fetch address is formed from a code segment and a prefetch offset. Both are set by reset and replaced together when control flow is redirected.

The bus side is a request/acknowledge handshake. A request stays high with a stable address until the acknowledge arrives, and the word is taken in the acknowledge cycle. The consumer side is valid/ready. A byte leaves when `op_valid_o` and `op_ready_i` are both high at a clock edge. While ready is low, the offered byte is held unchanged. When the queue is empty, valid is low and the consumer waits. An execution-side bus-use input stops new fetches from starting, which leaves the bus free for data transfers. A redirect input empties the queue at once. Any fetch still on the bus runs to its acknowledge, but its data is thrown away.

Top module: `prefetch_q`

## Requirements
- R1: During and right after reset, the code segment is FFFFh and the offset is 0. Valid is low, status is 00, and the first fetch request carries address FFFF0h.
- R2: The fetch address is (segment × 16 + offset) mod 2^20. The offset grows by 2 for every word that is kept. The address stays stable while a request waits for its acknowledge.
- R3: A request starts only when no fetch is outstanding and at least 2 of the 6 byte slots are free. The queue never holds more than 6 bytes.
- R4: An acknowledged word enqueues bits 7:0 first (the byte at the fetch address) and then bits 15:8 (the byte at the address plus 1).
- R5: A byte is removed only on valid and ready together, and bytes come out in address order. Valid is low exactly when the queue is empty. While valid is high and ready is low, the byte is held stable.
- R6: While `ex_bus_busy_i` is high, no new request starts. A request that is already outstanding stays up until it is acknowledged.
- R7: A redirect (`flush_i`) empties the queue by the next cycle and loads the new segment and offset. The next kept bytes come from the new address. A fetch outstanding at the redirect, or acknowledged in the redirect cycle, is not enqueued.
- R8: `qs_o` is registered and shows the previous cycle's operation. 00 means nothing happened. 01 means a byte was taken with `op_first_i` high. 11 means a byte was taken with `op_first_i` low. 10 means the queue was emptied by a redirect.
- R9: A redirect in the same cycle as a valid/ready transfer wins. The byte is dropped and the status is 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_req_o | output | 1 | Code fetch request, held until acknowledged |
| fetch_addr_o | output | 20 | Physical fetch address |
| fetch_ack_i | input | 1 | Fetch acknowledge; data valid this cycle |
| fetch_data_i | input | 16 | Fetched word, low byte at the lower address |
| ex_bus_busy_i | input | 1 | Execution side owns the bus; no new fetch may start |
| flush_i | input | 1 | Redirect: empty the queue and reload segment and offset |
| flush_seg_i | input | 16 | New code segment on redirect |
| flush_off_i | input | 16 | New prefetch offset on redirect |
| op_valid_o | output | 1 | An opcode byte is available |
| op_byte_o | output | 8 | Oldest opcode byte |
| op_ready_i | input | 1 | Consumer takes the byte this cycle |
| op_first_i | input | 1 | Marks the taken byte as the first opcode byte |
| qs_o | output | 2 | Queue status of the previous clock |

## Verification
A request starts one edge after the cycle in which the issue conditions hold. An acknowledged word raises the byte count at the next edge. A taken byte is replaced on `op_byte_o` right after that edge. The status code for a cycle's operation shows up exactly one edge later. The bench sets its inputs 1 ns after each rising edge and keeps a model of the queue. It updates the model for the transfers in that cycle, then reads the outputs 1 ns after the next edge. Each output is compared there with the value the model predicts for that edge. Redirects land at fixed cycles, while fetch latency, consumer patterns and bus-busy windows vary. This makes some redirects fall while a fetch is in flight and some coincide with a transfer.

// File: rtl/pfq_pkg.sv
package pfq_pkg;
  typedef enum logic [1:0] {
    QS_IDLE  = 2'b00,
    QS_FIRST = 2'b01,
    QS_FLUSH = 2'b10,
    QS_NEXT  = 2'b11
  } qs_e;
endpackage

// File: rtl/pfq_addr_gen.sv
module pfq_addr_gen #(
  parameter int SEG_W     = 16,
  parameter int OFF_W     = 16,
  parameter int PA_W      = 20,
  parameter int SEG_SHIFT = 4,
  parameter int STEP      = 2,
  parameter logic [SEG_W-1:0] RST_SEG = '1,
  parameter logic [OFF_W-1:0] RST_OFF = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [SEG_W-1:0] load_seg_i,
  input  logic [OFF_W-1:0] load_off_i,
  input  logic             adv_i,
  output logic [PA_W-1:0]  pa_o
);
  localparam logic [OFF_W-1:0] STEP_V = OFF_W'(STEP);

  logic [SEG_W-1:0] seg_q;
  logic [OFF_W-1:0] off_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seg_q <= RST_SEG;
      off_q <= RST_OFF;
    end else if (load_i) begin
      seg_q <= load_seg_i;
      off_q <= load_off_i;
    end else if (adv_i) begin
      off_q <= off_q + STEP_V;
    end
  end

  always_comb begin
    pa_o = (PA_W'(seg_q) << SEG_SHIFT) + PA_W'(off_q);
  end
endmodule

// File: rtl/pfq_byte_fifo.sv
module pfq_byte_fifo #(
  parameter int DEPTH = 6,
  parameter int LANES = 2,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clear_i,
  input  logic               push_i,
  input  logic [8*LANES-1:0] push_data_i,
  input  logic               pop_i,
  output logic [7:0]         data_o,
  output logic [CNT_W-1:0]   count_o,
  output logic [CNT_W-1:0]   free_o
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  function automatic logic [PTR_W-1:0] wrap(input logic [PTR_W-1:0] p, input int k);
    int s;
    s = int'(p) + k;
    return PTR_W'(s % DEPTH);
  endfunction

  logic [7:0]       mem_q [DEPTH];
  logic [PTR_W-1:0] wr_q, rd_q;
  logic [CNT_W-1:0] cnt_q;
  logic [PTR_W-1:0] lane_idx [LANES];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_comb lane_idx[g] = wrap(wr_q, g);
    always_ff @(posedge clk) begin
      if (push_i && !clear_i) mem_q[lane_idx[g]] <= push_data_i[8*g +: 8];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clear_i) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_i) wr_q <= wrap(wr_q, LANES);
      if (pop_i)  rd_q <= wrap(rd_q, 1);
      cnt_q <= cnt_q + (push_i ? CNT_W'(LANES) : '0) - (pop_i ? CNT_W'(1) : '0);
    end
  end

  assign data_o  = mem_q[rd_q];
  assign count_o = cnt_q;
  assign free_o  = CNT_W'(DEPTH) - cnt_q;
endmodule

// File: rtl/pfq_qstat.sv
module pfq_qstat
  import pfq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       flush_i,
  input  logic       take_i,
  input  logic       first_i,
  output logic [1:0] qs_o
);
  qs_e qs_q, qs_d;

  always_comb begin
    if (flush_i)     qs_d = QS_FLUSH;
    else if (take_i) qs_d = first_i ? QS_FIRST : QS_NEXT;
    else             qs_d = QS_IDLE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) qs_q <= QS_IDLE;
    else        qs_q <= qs_d;
  end

  assign qs_o = qs_q;
endmodule

// File: rtl/prefetch_q.sv
module prefetch_q #(
  parameter int DEPTH      = 6,
  parameter int WORD_BYTES = 2,
  parameter int SEG_W      = 16,
  parameter int OFF_W      = 16,
  parameter int PA_W       = 20,
  parameter int SEG_SHIFT  = 4,
  parameter logic [SEG_W-1:0] RST_SEG = '1,
  parameter logic [OFF_W-1:0] RST_OFF = '0
) (
  input  logic                    clk,
  input  logic                    rst_n,
  output logic                    fetch_req_o,
  output logic [PA_W-1:0]         fetch_addr_o,
  input  logic                    fetch_ack_i,
  input  logic [8*WORD_BYTES-1:0] fetch_data_i,
  input  logic                    ex_bus_busy_i,
  input  logic                    flush_i,
  input  logic [SEG_W-1:0]        flush_seg_i,
  input  logic [OFF_W-1:0]        flush_off_i,
  output logic                    op_valid_o,
  output logic [7:0]              op_byte_o,
  input  logic                    op_ready_i,
  input  logic                    op_first_i,
  output logic [1:0]              qs_o
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic             req_q, drop_q;
  logic [PA_W-1:0]  addr_q;
  logic [PA_W-1:0]  pa_w;
  logic [CNT_W-1:0] occ_w, free_w;
  logic             ack_hit, push, take, issue;

  assign ack_hit = req_q && fetch_ack_i;
  assign push    = ack_hit && !drop_q && !flush_i;
  assign take    = op_valid_o && op_ready_i && !flush_i;
  assign issue   = !req_q && !ex_bus_busy_i && !flush_i && (free_w >= CNT_W'(WORD_BYTES));

  pfq_addr_gen #(
    .SEG_W(SEG_W), .OFF_W(OFF_W), .PA_W(PA_W), .SEG_SHIFT(SEG_SHIFT),
    .STEP(WORD_BYTES), .RST_SEG(RST_SEG), .RST_OFF(RST_OFF)
  ) addr_i (
    .clk(clk), .rst_n(rst_n), .load_i(flush_i), .load_seg_i(flush_seg_i),
    .load_off_i(flush_off_i), .adv_i(push), .pa_o(pa_w)
  );

  pfq_byte_fifo #(.DEPTH(DEPTH), .LANES(WORD_BYTES), .CNT_W(CNT_W)) fifo_i (
    .clk(clk), .rst_n(rst_n), .clear_i(flush_i), .push_i(push),
    .push_data_i(fetch_data_i), .pop_i(take), .data_o(op_byte_o),
    .count_o(occ_w), .free_o(free_w)
  );

  pfq_qstat qstat_i (
    .clk(clk), .rst_n(rst_n), .flush_i(flush_i), .take_i(take),
    .first_i(op_first_i), .qs_o(qs_o)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_q  <= 1'b0;
      drop_q <= 1'b0;
      addr_q <= '0;
    end else begin
      if (issue) begin
        req_q  <= 1'b1;
        addr_q <= pa_w;
      end else if (ack_hit) begin
        req_q  <= 1'b0;
      end
      if (ack_hit)                drop_q <= 1'b0;
      else if (flush_i && req_q)  drop_q <= 1'b1;
    end
  end

  assign fetch_req_o  = req_q;
  assign fetch_addr_o = addr_q;
  assign op_valid_o   = (occ_w != '0);
endmodule

// File: rtl/pfq_checker.sv
module pfq_checker #(
  parameter int DEPTH = 6,
  parameter int PA_W  = 20,
  parameter int CNT_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             fetch_req_o,
  input logic [PA_W-1:0]  fetch_addr_o,
  input logic             fetch_ack_i,
  input logic             ex_bus_busy_i,
  input logic             flush_i,
  input logic             op_valid_o,
  input logic [7:0]       op_byte_o,
  input logic             op_ready_i,
  input logic [1:0]       qs_o,
  input logic [CNT_W-1:0] occ_i
);
  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    occ_i <= CNT_W'(DEPTH));

  a_r3_issue_room: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fetch_req_o) |-> occ_i <= CNT_W'(DEPTH - 2));

  a_r2_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_req_o && !fetch_ack_i |=> fetch_req_o && $stable(fetch_addr_o));

  a_r6_busy_no_issue: assert property (@(posedge clk) disable iff (!rst_n)
    ex_bus_busy_i && !fetch_req_o |=> !fetch_req_o);

  a_r5_hold_byte: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid_o && !op_ready_i && !flush_i |=> op_valid_o && $stable(op_byte_o));

  a_r7_flush_empty: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |=> !op_valid_o);

  a_r8_flush_code: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |=> qs_o == 2'b10);

  a_r8_idle_code: assert property (@(posedge clk) disable iff (!rst_n)
    !flush_i && !(op_valid_o && op_ready_i) |=> qs_o == 2'b00);
endmodule

bind prefetch_q pfq_checker #(.DEPTH(DEPTH), .PA_W(PA_W), .CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .fetch_req_o(fetch_req_o), .fetch_addr_o(fetch_addr_o),
  .fetch_ack_i(fetch_ack_i), .ex_bus_busy_i(ex_bus_busy_i), .flush_i(flush_i),
  .op_valid_o(op_valid_o), .op_byte_o(op_byte_o), .op_ready_i(op_ready_i),
  .qs_o(qs_o), .occ_i(occ_w)
);

// File: tb/prefetch_q_tb_top.sv
module prefetch_q_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fetch_req_o;
  logic [19:0] fetch_addr_o;
  logic        fetch_ack_i = 1'b0;
  logic [15:0] fetch_data_i = '0;
  logic        ex_bus_busy_i = 1'b0;
  logic        flush_i = 1'b0;
  logic [15:0] flush_seg_i = '0;
  logic [15:0] flush_off_i = '0;
  logic        op_valid_o;
  logic [7:0]  op_byte_o;
  logic        op_ready_i = 1'b0;
  logic        op_first_i = 1'b0;
  logic [1:0]  qs_o;

  always #5 clk = ~clk;

  prefetch_q dut_i (
    .clk(clk), .rst_n(rst_n), .fetch_req_o(fetch_req_o), .fetch_addr_o(fetch_addr_o),
    .fetch_ack_i(fetch_ack_i), .fetch_data_i(fetch_data_i), .ex_bus_busy_i(ex_bus_busy_i),
    .flush_i(flush_i), .flush_seg_i(flush_seg_i), .flush_off_i(flush_off_i),
    .op_valid_o(op_valid_o), .op_byte_o(op_byte_o), .op_ready_i(op_ready_i),
    .op_first_i(op_first_i), .qs_o(qs_o)
  );

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  // bench model
  logic [15:0] m_seg = 16'hFFFF;
  logic [15:0] m_fptr = 16'h0000;
  logic [15:0] m_cptr = 16'h0000;
  int          m_occ = 0;
  bit          m_drop = 0;
  bit          m_seen = 0;
  int          lat = 0;
  int          wcnt = 0;

  function automatic logic [19:0] pa(input logic [15:0] s, input logic [15:0] o);
    return 20'({s, 4'h0}) + 20'(o);
  endfunction

  function automatic logic [7:0] bval(input logic [19:0] a);
    return a[7:0] ^ a[15:8] ^ {4'h0, a[19:16]} ^ 8'h5B;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input bit rdy, input bit first, input bit busy, input bit fl,
                     input logic [15:0] fseg, input logic [15:0] foff);
    bit took, ack, req_before, hold;
    logic [7:0] byte_before;
    // bus responder and new-request checks
    ack = 0;
    if (fetch_req_o) begin
      if (!m_seen) begin
        chk(fetch_addr_o == pa(m_seg, m_fptr), "R2 fetch address", int'(fetch_addr_o),
            int'(pa(m_seg, m_fptr)));
        chk(m_occ <= 4, "R3 room at issue", m_occ, 4);
        m_seen = 1;
      end
      if (wcnt >= lat) ack = 1;
    end
    fetch_ack_i  = ack;
    fetch_data_i = ack ? {bval(fetch_addr_o + 20'd1), bval(fetch_addr_o)} : 16'h0;
    took = rdy && op_valid_o && !fl;
    if (took) begin
      chk(op_byte_o == bval(pa(m_seg, m_cptr)), "R4 R5 byte order", int'(op_byte_o),
          int'(bval(pa(m_seg, m_cptr))));
    end
    hold        = op_valid_o && !rdy && !fl;
    byte_before = op_byte_o;
    req_before  = fetch_req_o;
    op_ready_i    = rdy;
    op_first_i    = first;
    ex_bus_busy_i = busy;
    flush_i       = fl;
    flush_seg_i   = fseg;
    flush_off_i   = foff;
    @(posedge clk);
    #1;
    // model update for this cycle
    if (ack) begin
      if (!m_drop && !fl) begin
        m_occ  += 2;
        m_fptr += 16'd2;
      end
      m_drop = 0;
      m_seen = 0;
      wcnt   = 0;
    end else begin
      if (fl && req_before) m_drop = 1;
      if (req_before) wcnt++;
    end
    if (took) begin
      m_occ--;
      m_cptr += 16'd1;
    end
    if (fl) begin
      m_occ  = 0;
      m_seg  = fseg;
      m_fptr = foff;
      m_cptr = foff;
    end
    // post-edge checks
    if (fl)
      chk(qs_o == 2'b10, rdy ? "R9 flush beats take" : "R8 flush code", int'(qs_o), 2);
    else if (took)
      chk(qs_o == (first ? 2'b01 : 2'b11), "R8 take code", int'(qs_o), first ? 1 : 3);
    else
      chk(qs_o == 2'b00, "R8 idle code", int'(qs_o), 0);
    chk(op_valid_o == (m_occ != 0), fl ? "R7 flush empties" : "R5 valid vs occupancy",
        int'(op_valid_o), int'(m_occ != 0));
    chk(m_occ <= 6, "R3 capacity", m_occ, 6);
    if (hold) chk(op_byte_o == byte_before, "R5 hold while not ready", int'(op_byte_o),
                  int'(byte_before));
    if (busy && !req_before) chk(!fetch_req_o, "R6 no issue while busy", int'(fetch_req_o), 0);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk(!fetch_req_o, "R1 no request in reset", int'(fetch_req_o), 0);
    chk(!op_valid_o, "R1 empty in reset", int'(op_valid_o), 0);
    chk(qs_o == 2'b00, "R1 status in reset", int'(qs_o), 0);
    rst_n = 1'b1;
    cyc(0, 0, 0, 0, 16'h0, 16'h0);
    chk(fetch_req_o && fetch_addr_o == 20'hFFFF0, "R1 first fetch address",
        int'(fetch_addr_o), 'hFFFF0);
    // sweep latency, consumer pattern and busy windows, with a redirect in each run
    for (int l = 0; l < 4; l++) begin
      for (int p = 0; p < 4; p++) begin
        logic [15:0] ns, no;
        lat = l;
        if (l == 3 && p == 3) begin
          ns = 16'hFFFF;
          no = 16'hFFF0;
        end else begin
          ns = 16'(16'h0123 * (l * 4 + p + 1));
          no = 16'(16'h0222 * (p + 1)) & 16'hFFFE;
        end
        for (int c = 0; c < 48; c++) begin
          bit r, b;
          case (p)
            0: r = 1;
            1: r = (c % 2 == 0);
            2: r = (c % 3 == 0);
            default: r = (c >= 20);
          endcase
          b = ((l + p) % 2 == 1) && (c % 7 < 3);
          cyc(r, (c % 4 == 0), b, (c == 30 + l), ns, no);
        end
      end
    end
    // empty stall: slow bus, eager consumer
    lat = 40;
    for (int c = 0; c < 60; c++) cyc(1, 0, 0, 0, 16'h0, 16'h0);
    chk(!op_valid_o, "R5 empty stalls", int'(op_valid_o), 0);
    // long busy window: queue drains, nothing new starts
    lat = 0;
    for (int c = 0; c < 20; c++) cyc(1, 1, 1, 0, 16'h0, 16'h0);
    chk(!fetch_req_o, "R6 idle bus after busy window", int'(fetch_req_o), 0);
    for (int c = 0; c < 20; c++) cyc(c % 2 == 0, 0, 0, 0, 16'h0, 16'h0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule